// File: doc/BRIEF.md
# Sleep Wake Detector

This block stands between the bus receiver, the local wake pin and the mode controller of a low-power bus node. It recognises the two events that may end sleep. The first is a bus wake: the bus leaves recessive, stays dominant for longer than a bus filter time, then returns to recessive. The second is a local wake: the wake pin falls and stays low for longer than a local filter time. Each qualified event produces a single-cycle request pulse on its own output. The mode controller uses these pulses to leave sleep.

The bus level, the pre-wake comparator flag and the wake pin level are asynchronous to the block clock. Each passes through a synchronizer of `SYNC_STAGES` flops before any edge is detected. The bus level and the pre-wake flag share one synchronizer, so they stay aligned with each other. Both filter times, and the high time the wake pin needs before a new falling edge is accepted, are given in clock cycles. The defaults suit a 50 MHz clock: 100 µs filters and a 10 µs re-arm time. Detection runs only while `sleep_i` is high. Sleep can start at any bus or pin level.

A sample is the value of an input as seen after synchronization, one per clock. `bus_dom_i` = 1 means dominant. `wake_pin_i` = 1 means the pin is high. `prewake_i` = 1 means the bus is below the pre-wake low threshold.

Top module: `sleep_wake_detector`

## Requirements
- R1: In sleep, a dominant run that starts with a recessive-to-dominant change while `prewake_i` is 1 and lasts at least `BUS_FILT_CYC`+1 samples raises `bus_wake_o` when the bus returns to recessive. The pulse appears after the (`SYNC_STAGES`+1)-th rising clock edge, counting the edge that first samples the recessive level.
- R2: A dominant run of `BUS_FILT_CYC` samples or fewer produces no bus request.
- R3: A dominant run produces no bus request in three cases: `prewake_i` is 0 at its first dominant sample, `prewake_i` drops to 0 during the run, or the bus was already dominant when sleep was entered.
- R4: In sleep, after an accepted high-to-low change, `local_wake_o` pulses as soon as `LOC_FILT_CYC`+1 consecutive low samples have been seen. No return to high is needed.
- R5: A low period of `LOC_FILT_CYC` samples or fewer produces no local request.
- R6: A high-to-low change of the wake pin is accepted only if the pin was high for more than `REARM_CYC` consecutive samples just before it. This covers a pin that is low when sleep begins and a pin still held low after a request.
- R7: While `sleep_i` is 0 both outputs stay 0. Leaving sleep discards any partly counted run, and the run does not resume after sleep is entered again.
- R8: Each request is exactly one cycle wide. A bus request and a local request may be raised in the same cycle.
- R9: While `rst_n` is 0 both outputs are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| sleep_i | input | 1 | 1 while the node is in sleep mode (synchronous) |
| prewake_i | input | 1 | 1 while the bus is below the pre-wake low threshold (asynchronous) |
| bus_dom_i | input | 1 | Bus receive level, 1 = dominant (asynchronous) |
| wake_pin_i | input | 1 | Local wake pin level, 1 = high (asynchronous) |
| bus_wake_o | output | 1 | One-cycle bus wake request |
| local_wake_o | output | 1 | One-cycle local wake request |

## Verification
The bus path fires on the sample where the bus returns to recessive. The local path fires on the sample that completes its low count. These two detections can land on the same clock edge. The bench provokes this by starting a 20-sample dominant run and dropping the wake pin exactly `LOC_FILT_CYC` samples later, so both conditions are met on one sample. It then counts the cycles in which both outputs are high and expects exactly one, while the per-cycle model confirms that neither pulse is lost or delayed.

// File: rtl/wkd_pkg.sv
package wkd_pkg;
   // bus-side sample pair; both bits cross the clock boundary together
   typedef struct packed {
      logic pre;   // below pre-wake threshold
      logic dom;   // bus dominant
   } bus_samp_t;

   localparam int unsigned BUS_SAMP_W = $bits(bus_samp_t);
endpackage

// File: rtl/wkd_sync.sv
module wkd_sync #(
   parameter int unsigned   WIDTH   = 1,
   parameter int unsigned   STAGES  = 2,
   parameter logic [WIDTH-1:0] RST_VAL = '0
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [WIDTH-1:0] d_i,
   output logic [WIDTH-1:0] q_o
);
   logic [STAGES-1:0][WIDTH-1:0] stg;

   generate
      if (STAGES == 1) begin : g_single
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) stg[0] <= RST_VAL;
            else        stg[0] <= d_i;
         end
      end else begin : g_chain
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) stg <= {STAGES{RST_VAL}};
            else        stg <= {stg[STAGES-2:0], d_i};
         end
      end
   endgenerate

   assign q_o = stg[STAGES-1];
endmodule

// File: rtl/wkd_bus_filter.sv
module wkd_bus_filter #(
   parameter int unsigned FILT_CYC = 5000
) (
   input  logic clk,
   input  logic rst_n,
   input  logic sleep_i,
   input  logic dom_i,
   input  logic pre_i,
   output logic wake_o
);
   localparam int unsigned SAT = FILT_CYC + 1;
   localparam int unsigned CW  = $clog2(SAT + 1);

   logic          dom_d;
   logic          active;
   logic [CW-1:0] cnt;
   logic          fall_edge, rise_edge;

   assign fall_edge = dom_i & ~dom_d;   // bus pulled dominant
   assign rise_edge = ~dom_i & dom_d;   // bus released

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         dom_d  <= 1'b0;
         active <= 1'b0;
         cnt    <= '0;
         wake_o <= 1'b0;
      end else begin
         dom_d  <= dom_i;
         wake_o <= 1'b0;
         if (!sleep_i) begin
            active <= 1'b0;
            cnt    <= '0;
         end else if (active) begin
            if (rise_edge) begin
               wake_o <= (cnt == CW'(SAT));
               active <= 1'b0;
               cnt    <= '0;
            end else if (!pre_i) begin
               active <= 1'b0;
               cnt    <= '0;
            end else if (cnt != CW'(SAT)) begin
               cnt <= cnt + 1'b1;
            end
         end else if (fall_edge && pre_i) begin
            active <= 1'b1;
            cnt    <= CW'(1);
         end
      end
   end
endmodule

// File: rtl/wkd_local_filter.sv
module wkd_local_filter #(
   parameter int unsigned FILT_CYC  = 5000,
   parameter int unsigned REARM_CYC = 500
) (
   input  logic clk,
   input  logic rst_n,
   input  logic sleep_i,
   input  logic lvl_i,
   output logic wake_o
);
   localparam int unsigned HSAT = REARM_CYC + 1;
   localparam int unsigned HW   = $clog2(HSAT + 1);
   localparam int unsigned LW   = $clog2(FILT_CYC + 1);

   logic          lvl_d;
   logic [HW-1:0] hi_cnt;
   logic          active;
   logic [LW-1:0] cnt;
   logic          fall_edge, armed;

   assign fall_edge = ~lvl_i & lvl_d;
   assign armed     = (hi_cnt == HW'(HSAT));

   // high-time monitor runs in every mode so a pin high before sleep counts
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                     hi_cnt <= '0;
      else if (!lvl_i)                hi_cnt <= '0;
      else if (hi_cnt != HW'(HSAT))   hi_cnt <= hi_cnt + 1'b1;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         lvl_d  <= 1'b1;
         active <= 1'b0;
         cnt    <= '0;
         wake_o <= 1'b0;
      end else begin
         lvl_d  <= lvl_i;
         wake_o <= 1'b0;
         if (!sleep_i) begin
            active <= 1'b0;
            cnt    <= '0;
         end else if (active) begin
            if (lvl_i) begin
               active <= 1'b0;
               cnt    <= '0;
            end else if (cnt == LW'(FILT_CYC)) begin
               wake_o <= 1'b1;
               active <= 1'b0;
               cnt    <= '0;
            end else begin
               cnt <= cnt + 1'b1;
            end
         end else if (fall_edge && armed) begin
            active <= 1'b1;
            cnt    <= LW'(1);
         end
      end
   end
endmodule

// File: rtl/sleep_wake_detector.sv
module sleep_wake_detector #(
   parameter int unsigned SYNC_STAGES  = 2,
   parameter int unsigned BUS_FILT_CYC = 5000,
   parameter int unsigned LOC_FILT_CYC = 5000,
   parameter int unsigned REARM_CYC    = 500
) (
   input  logic clk,
   input  logic rst_n,
   input  logic sleep_i,
   input  logic prewake_i,
   input  logic bus_dom_i,
   input  logic wake_pin_i,
   output logic bus_wake_o,
   output logic local_wake_o
);
   import wkd_pkg::*;

   generate
      if (SYNC_STAGES < 2) begin : g_chk_sync
         $error("SYNC_STAGES must be at least 2");
      end
      if (BUS_FILT_CYC < 1) begin : g_chk_bus
         $error("BUS_FILT_CYC must be at least 1");
      end
      if (LOC_FILT_CYC < 1) begin : g_chk_loc
         $error("LOC_FILT_CYC must be at least 1");
      end
   endgenerate

   bus_samp_t bus_raw, bus_syn;
   logic      bus_dom_s, bus_pre_s, loc_lvl_s;

   assign bus_raw.pre = prewake_i;
   assign bus_raw.dom = bus_dom_i;

   wkd_sync #(.WIDTH(BUS_SAMP_W), .STAGES(SYNC_STAGES), .RST_VAL('0)) u_bus_sync (
      .clk(clk), .rst_n(rst_n), .d_i(bus_raw), .q_o(bus_syn)
   );

   wkd_sync #(.WIDTH(1), .STAGES(SYNC_STAGES), .RST_VAL(1'b1)) u_loc_sync (
      .clk(clk), .rst_n(rst_n), .d_i(wake_pin_i), .q_o(loc_lvl_s)
   );

   assign bus_dom_s = bus_syn.dom;
   assign bus_pre_s = bus_syn.pre;

   wkd_bus_filter #(.FILT_CYC(BUS_FILT_CYC)) u_bus_filt (
      .clk(clk), .rst_n(rst_n), .sleep_i(sleep_i),
      .dom_i(bus_dom_s), .pre_i(bus_pre_s), .wake_o(bus_wake_o)
   );

   wkd_local_filter #(.FILT_CYC(LOC_FILT_CYC), .REARM_CYC(REARM_CYC)) u_loc_filt (
      .clk(clk), .rst_n(rst_n), .sleep_i(sleep_i),
      .lvl_i(loc_lvl_s), .wake_o(local_wake_o)
   );
endmodule

// File: rtl/wkd_checker.sv
module wkd_checker (
   input logic clk,
   input logic rst_n,
   input logic sleep_i,
   input logic bus_dom_s,
   input logic loc_lvl_s,
   input logic bus_wake_o,
   input logic local_wake_o
);
   // R8: bus request is one cycle wide
   assert_bus_single_R8: assert property (@(posedge clk) disable iff (!rst_n)
      bus_wake_o |=> !bus_wake_o);

   // R8: local request is one cycle wide
   assert_loc_single_R8: assert property (@(posedge clk) disable iff (!rst_n)
      local_wake_o |=> !local_wake_o);

   // R7: no request follows an awake cycle
   assert_awake_silent_R7: assert property (@(posedge clk) disable iff (!rst_n)
      !sleep_i |=> (!bus_wake_o && !local_wake_o));

   // R1: a bus request is raised only once the bus has been seen recessive
   assert_bus_after_release_R1: assert property (@(posedge clk) disable iff (!rst_n)
      bus_wake_o |-> !$past(bus_dom_s));

   // R4: a local request is raised only while the pin is seen low
   assert_loc_while_low_R4: assert property (@(posedge clk) disable iff (!rst_n)
      local_wake_o |-> !$past(loc_lvl_s));
endmodule

bind sleep_wake_detector wkd_checker u_wkd_checker (
   .clk(clk), .rst_n(rst_n), .sleep_i(sleep_i),
   .bus_dom_s(bus_dom_s), .loc_lvl_s(loc_lvl_s),
   .bus_wake_o(bus_wake_o), .local_wake_o(local_wake_o)
);

// File: tb/sleep_wake_detector_bench.sv
module sleep_wake_detector_bench;
   localparam int SYNC  = 2;
   localparam int BUSF  = 12;
   localparam int LOCF  = 10;
   localparam int REARM = 4;

   logic clk = 1'b0, rst_n = 1'b0;
   logic sleep = 1'b0, pre = 1'b0, dom = 1'b0, pin = 1'b1;
   logic bw, lw;

   always #10 clk = ~clk;   // 50 MHz

   sleep_wake_detector #(.SYNC_STAGES(SYNC), .BUS_FILT_CYC(BUSF),
                         .LOC_FILT_CYC(LOCF), .REARM_CYC(REARM)) u_sleep_wake_detector (
      .clk(clk), .rst_n(rst_n), .sleep_i(sleep), .prewake_i(pre),
      .bus_dom_i(dom), .wake_pin_i(pin), .bus_wake_o(bw), .local_wake_o(lw)
   );

   int    compared = 0, mismatched = 0;
   int    nbus = 0, nloc = 0, nboth = 0;
   string phase = "R9";

   // behavioural reference: sample delay lines and run lengths
   bit dq[$], pq[$], lq[$];
   bit d_prev, l_prev, exp_bw, exp_lw;
   int brun, lrun, hi_run;

   always @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         dq = {}; pq = {}; lq = {};
         for (int i = 0; i < SYNC; i++) begin
            dq.push_back(1'b0); pq.push_back(1'b0); lq.push_back(1'b1);
         end
         d_prev = 1'b0; l_prev = 1'b1;
         brun = -1; lrun = -1; hi_run = 0;
         exp_bw = 1'b0; exp_lw = 1'b0;
      end else begin
         bit s, p, l;
         s = dq[0]; p = pq[0]; l = lq[0];
         exp_bw = 1'b0; exp_lw = 1'b0;
         if (!sleep) begin
            brun = -1; lrun = -1;
         end else begin
            if (brun >= 0) begin
               if (!s) begin exp_bw = (brun > BUSF); brun = -1; end
               else if (!p) brun = -1;
               else brun++;
            end else if (s && !d_prev && p) brun = 1;
            if (lrun >= 0) begin
               if (l) lrun = -1;
               else if (lrun == LOCF) begin exp_lw = 1'b1; lrun = -1; end
               else lrun++;
            end else if (!l && l_prev && hi_run > REARM) lrun = 1;
         end
         hi_run = l ? hi_run + 1 : 0;
         d_prev = s; l_prev = l;
         void'(dq.pop_front()); void'(pq.pop_front()); void'(lq.pop_front());
         dq.push_back(dom); pq.push_back(pre); lq.push_back(pin);
      end
   end

   always @(negedge clk) begin
      if (rst_n) begin
         compared++;
         if (bw !== exp_bw || lw !== exp_lw) begin
            mismatched++;
            $display("FAIL %s: bus/local = %b/%b expected %b/%b", phase, bw, lw, exp_bw, exp_lw);
         end
         if (bw) nbus++;
         if (lw) nloc++;
         if (bw && lw) nboth++;
      end
   end

   task automatic wait_cyc(input int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic expect_counts(input string req, input int eb, input int el);
      compared++;
      if (nbus != eb || nloc != el) begin
         mismatched++;
         $display("FAIL %s: pulses bus=%0d local=%0d expected bus=%0d local=%0d",
                  req, nbus, nloc, eb, el);
      end
      nbus = 0; nloc = 0; nboth = 0;
   endtask

   task automatic bus_run(input int len);
      dom = 1'b1; wait_cyc(len);
      dom = 1'b0; wait_cyc(12);
   endtask

   initial begin
      // R9: reset state
      wait_cyc(3);
      compared++;
      if (bw !== 1'b0 || lw !== 1'b0) begin
         mismatched++;
         $display("FAIL R9: bus/local = %b/%b expected 0/0", bw, lw);
      end
      rst_n = 1'b1; sleep = 1'b1; pre = 1'b1;
      wait_cyc(10);
      expect_counts("R9", 0, 0);

      // R1: long run and boundary run
      phase = "R1";
      bus_run(20);         expect_counts("R1", 1, 0);
      bus_run(BUSF + 1);   expect_counts("R1", 1, 0);

      // R2: runs at or under the filter
      phase = "R2";
      bus_run(BUSF);       expect_counts("R2", 0, 0);
      bus_run(3);          expect_counts("R2", 0, 0);

      // R3: no pre-wake, pre-wake lost, dominant at sleep entry
      phase = "R3";
      pre = 1'b0; bus_run(20); pre = 1'b1;
      expect_counts("R3", 0, 0);
      dom = 1'b1; wait_cyc(5); pre = 1'b0; wait_cyc(1); pre = 1'b1; wait_cyc(15);
      dom = 1'b0; wait_cyc(12);
      expect_counts("R3", 0, 0);
      sleep = 1'b0; wait_cyc(3); dom = 1'b1; wait_cyc(5); sleep = 1'b1; wait_cyc(20);
      dom = 1'b0; wait_cyc(12);
      expect_counts("R3", 0, 0);

      // R4: boundary low and a long low without release
      phase = "R4";
      pin = 1'b0; wait_cyc(LOCF + 1); pin = 1'b1; wait_cyc(12);
      expect_counts("R4", 0, 1);
      pin = 1'b0; wait_cyc(30); pin = 1'b1; wait_cyc(12);
      expect_counts("R4", 0, 1);

      // R5: low at the filter length
      phase = "R5";
      pin = 1'b0; wait_cyc(LOCF); pin = 1'b1; wait_cyc(12);
      expect_counts("R5", 0, 0);

      // R6: pin low at sleep entry, short high, then long enough high
      phase = "R6";
      sleep = 1'b0; pin = 1'b0; wait_cyc(5); sleep = 1'b1; wait_cyc(3);
      pin = 1'b1; wait_cyc(REARM); pin = 1'b0; wait_cyc(20);
      expect_counts("R6", 0, 0);
      pin = 1'b1; wait_cyc(REARM + 1); pin = 1'b0; wait_cyc(20);
      pin = 1'b1; wait_cyc(12);
      expect_counts("R6", 0, 1);

      // R7: sleep left mid-run, and activity while awake
      phase = "R7";
      dom = 1'b1; wait_cyc(8); sleep = 1'b0; wait_cyc(3); sleep = 1'b1; wait_cyc(15);
      dom = 1'b0; wait_cyc(12);
      expect_counts("R7", 0, 0);
      sleep = 1'b0;
      bus_run(20);
      pin = 1'b0; wait_cyc(20); pin = 1'b1; wait_cyc(12);
      expect_counts("R7", 0, 0);
      sleep = 1'b1; wait_cyc(10);

      // R8: both requests on the same sample
      phase = "R8";
      dom = 1'b1; wait_cyc(10); pin = 1'b0; wait_cyc(10);
      dom = 1'b0; wait_cyc(15); pin = 1'b1;
      compared++;
      if (nboth != 1) begin
         mismatched++;
         $display("FAIL R8: same-cycle pulses = %0d expected 1", nboth);
      end
      wait_cyc(12);
      expect_counts("R8", 1, 1);

      $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
      $finish;
   end

   initial begin
      repeat (200000) @(posedge clk);
      mismatched++;
      $display("FAIL watchdog: run still active, expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
      $finish;
   end
endmodule